// File: doc/BRIEF.md
# Dual-Bank Read Path Router

This block sits on the read side of a two-bank flash controller. It decides what each read cycle returns, and it lets one bank be read while the other is busy with command entry or a program/erase run. For every access it decodes which bank the address falls in. If that bank is busy, the cycle returns the latched status byte, with no command needed. Otherwise it returns array data from a behavioural memory port, the status byte, or an identifier code, depending on the held read mode. It also produces the enable for the tri-state data drivers.

The status byte is copied in only when the second of the two strobes, chip-enable or output-enable, goes low. A host that wants a fresh status value therefore has to toggle a strobe. A low level on `pd_n` models deep power-down: it forces the outputs off, returns the read mode to array and sets the status copy to 80h. An idle timer puts the block into a power-save hold that freezes the returned word until the address or chip-enable moves.

The controlling state machine has three states. `ST_DOWN` is held during power-down. The *release* transition leads from it to `ST_ACTIVE`, where a fresh read is registered every cycle. The *idle expiry* transition leads to `ST_SAVE` after `IDLE_CYC` cycles with no change, and there the output word is frozen. The *input change* transition leads from `ST_SAVE` back to `ST_ACTIVE` and registers a fresh read in the same cycle.

Top module: `dbank_read_router`

## Requirements
- R1: A read whose address falls in a bank whose `bank_busy` bit is 1 returns the latched status byte, zero-extended, whatever the read mode. `bank_busy[0]` belongs to the lower bank and `bank_busy[1]` to the upper bank.
- R2: While one bank is busy, a read of the other bank returns array data (`mem_rdata` for `mem_addr` = `addr`) in read-array mode, with no command.
- R3: In identifier mode (`mode_sel` = 2'b10), address 0 returns `mfr_code`, address 1 returns `dev_code` and any other address returns 0.
- R4: The status copy loads `stat_in` only in the cycle where chip-enable and output-enable are first both low. While both stay low, a change of `stat_in` is not seen. The value taken is the one present when the later of the two strobes falls.
- R5: `dout_oe` is 0 whenever `oe_n` is 1, `ce_n` is 1 or `pd_n` is 0, and is 1 otherwise.
- R6: After `pd_n` is released, the read mode is read-array (2'b00) and the status copy reads 80h until the next capture.
- R7: After `IDLE_CYC` cycles with no change of `addr` or `ce_n`, `dout` holds its last word, even if the mode or busy flags change.
- R8: A change of `addr` or `ce_n` during the hold produces a fresh read. Before the idle time expires, other input changes show up on `dout`.
- R9: Addresses below `BOUND_ADDR` (default 20'h20000) belong to the lower bank. `BOUND_ADDR` and all addresses above it belong to the upper bank.
- R10: A pulse on `mode_ld` loads the read mode from `mode_sel`: 2'b00 array, 2'b01 status, 2'b10 identifier, 2'b11 array. Each read shows on `dout` one clock after its inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pd_n | input | 1 | Reset / deep power-down, active low |
| ce_n | input | 1 | Chip-enable strobe, active low |
| oe_n | input | 1 | Output-enable strobe, active low |
| addr | input | AW | Read address |
| mode_ld | input | 1 | Load the read mode from `mode_sel` |
| mode_sel | input | 2 | Read mode code |
| bank_busy | input | 2 | Busy flag per bank from the sequencer |
| stat_in | input | 8 | Live status register value |
| mfr_code | input | DW | Manufacturer identifier constant |
| dev_code | input | DW | Device identifier constant |
| mem_addr | output | AW | Address to the behavioural array port |
| mem_rdata | input | DW | Array data for `mem_addr` |
| dout | output | DW | Read data word |
| dout_oe | output | 1 | Tri-state driver enable |

## Verification
Two functions can act in the same cycle. A strobe falling can capture a new status byte in the same cycle that the status path is chosen because the addressed bank is busy. In the bench, the bank busy flag and a new `stat_in` change together with the output-enable toggle. The read is then checked two clocks later, where it must show the freshly latched byte and not the older one. The second collision is a hold being broken by an address change that also moves the read into a busy bank. That case is judged by whether the same clock that leaves `ST_SAVE` also returns status and not the frozen array word.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'b00,
        MODE_STATUS = 2'b01,
        MODE_IDENT  = 2'b10
    } rd_mode_e;

    typedef enum logic [1:0] {
        ST_DOWN   = 2'b00,
        ST_ACTIVE = 2'b01,
        ST_SAVE   = 2'b10
    } save_st_e;

    localparam logic [7:0] STAT_RESET = 8'h80;
endpackage

// File: rtl/dbr_bank_dec.sv
module dbr_bank_dec #(
    parameter int AW = 20,
    parameter logic [AW-1:0] BOUND_ADDR = 20'h20000
) (
    input  logic [AW-1:0] addr,
    output logic          bank_hi
);
    generate
        if (BOUND_ADDR == '0) begin : g_all_hi
            assign bank_hi = 1'b1;
        end else begin : g_cmp
            assign bank_hi = (addr >= BOUND_ADDR);
        end
    endgenerate
endmodule

// File: rtl/dbr_stat_latch.sv
module dbr_stat_latch (
    input  logic       clk,
    input  logic       pd_n,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic [7:0] stat_in,
    output logic [7:0] stat_q
);
    import dbr_pkg::*;

    logic strobe_off_q;
    logic capture;

    // capture only on the cycle the second strobe goes low
    assign capture = strobe_off_q && !ce_n && !oe_n;

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            strobe_off_q <= 1'b1;
            stat_q       <= STAT_RESET;
        end else begin
            strobe_off_q <= ce_n || oe_n;
            if (capture) stat_q <= stat_in;
        end
    end

    AST_STAT_NO_REFRESH: assert property (@(posedge clk) disable iff (!pd_n)
        (!ce_n && !oe_n && !strobe_off_q) |=> $stable(stat_q)); // R4
endmodule

// File: rtl/dbr_idle_fsm.sv
module dbr_idle_fsm #(
    parameter int AW       = 20,
    parameter int IDLE_CYC = 20
) (
    input  logic          clk,
    input  logic          pd_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    output logic          hold
);
    import dbr_pkg::*;

    localparam int CW = $clog2(IDLE_CYC + 1);

    save_st_e      st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [AW-1:0] addr_q;
    logic          ce_q;
    logic          chg;

    assign chg = (addr != addr_q) || (ce_n != ce_q);

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            st_q   <= ST_DOWN;
            cnt_q  <= '0;
            addr_q <= '0;
            ce_q   <= 1'b1;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            addr_q <= addr;
            ce_q   <= ce_n;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        hold  = 1'b0;
        unique case (st_q)
            ST_DOWN: begin
                st_d  = ST_ACTIVE;
                cnt_d = '0;
            end
            ST_ACTIVE: begin
                if (chg) begin
                    cnt_d = '0;
                end else if (cnt_q == CW'(IDLE_CYC - 1)) begin
                    st_d  = ST_SAVE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SAVE: begin
                if (chg) begin
                    st_d  = ST_ACTIVE;
                    cnt_d = '0;
                end else begin
                    hold = 1'b1;
                end
            end
            default: st_d = ST_DOWN;
        endcase
    end

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!pd_n)
        (st_q == ST_ACTIVE) |-> (cnt_q < CW'(IDLE_CYC))); // R7
    AST_SAVE_STAYS: assert property (@(posedge clk) disable iff (!pd_n)
        (st_q == ST_SAVE && !chg) |=> (st_q == ST_SAVE)); // R7
    AST_SAVE_EXIT: assert property (@(posedge clk) disable iff (!pd_n)
        (st_q == ST_SAVE && chg) |=> (st_q == ST_ACTIVE)); // R8
endmodule

// File: rtl/dbank_read_router.sv
module dbank_read_router #(
    parameter int AW       = 20,
    parameter int DW       = 16,
    parameter logic [AW-1:0] BOUND_ADDR = 20'h20000,
    parameter int IDLE_CYC = 20
) (
    input  logic          clk,
    input  logic          pd_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic          mode_ld,
    input  logic [1:0]    mode_sel,
    input  logic [1:0]    bank_busy,
    input  logic [7:0]    stat_in,
    input  logic [DW-1:0] mfr_code,
    input  logic [DW-1:0] dev_code,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] dout,
    output logic          dout_oe
);
    import dbr_pkg::*;

    rd_mode_e      mode_q;
    logic          bank_hi;
    logic [7:0]    stat_q;
    logic          hold;
    logic [DW-1:0] stat_ext;
    logic [DW-1:0] sel_d;
    logic [DW-1:0] data_q;

    dbr_bank_dec #(.AW(AW), .BOUND_ADDR(BOUND_ADDR)) u_dec (
        .addr    (addr),
        .bank_hi (bank_hi)
    );

    dbr_stat_latch u_stat (
        .clk     (clk),
        .pd_n    (pd_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .stat_in (stat_in),
        .stat_q  (stat_q)
    );

    dbr_idle_fsm #(.AW(AW), .IDLE_CYC(IDLE_CYC)) u_idle (
        .clk  (clk),
        .pd_n (pd_n),
        .addr (addr),
        .ce_n (ce_n),
        .hold (hold)
    );

    assign mem_addr = addr;
    assign stat_ext = {{(DW-8){1'b0}}, stat_q};

    // read mode register
    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n)        mode_q <= MODE_ARRAY;
        else if (mode_ld) mode_q <= (mode_sel == 2'b11) ? MODE_ARRAY : rd_mode_e'(mode_sel);
    end

    // read source selection
    always_comb begin
        sel_d = mem_rdata;
        if (bank_busy[bank_hi]) begin
            sel_d = stat_ext;
        end else begin
            unique case (mode_q)
                MODE_ARRAY:  sel_d = mem_rdata;
                MODE_STATUS: sel_d = stat_ext;
                MODE_IDENT: begin
                    if (addr == AW'(0))      sel_d = mfr_code;
                    else if (addr == AW'(1)) sel_d = dev_code;
                    else                     sel_d = '0;
                end
                default: sel_d = mem_rdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n)      data_q <= '0;
        else if (!hold) data_q <= sel_d;
    end

    assign dout    = data_q;
    assign dout_oe = pd_n && !ce_n && !oe_n;

    AST_BUSY_GIVES_STATUS: assert property (@(posedge clk) disable iff (!pd_n)
        (!hold && bank_busy[bank_hi]) |=> (data_q == $past(stat_ext))); // R1
    AST_IDENT_MFR: assert property (@(posedge clk) disable iff (!pd_n)
        (!hold && !bank_busy[bank_hi] && mode_q == MODE_IDENT && addr == AW'(0))
        |=> (data_q == $past(mfr_code))); // R3
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!pd_n)
        hold |=> $stable(data_q)); // R7
endmodule

// File: tb/dbank_read_router_test.sv
module dbank_read_router_test;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int NV = 10;

    logic          clk = 1'b0;
    logic          pd_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          mode_ld = 1'b0;
    logic [1:0]    mode_sel = 2'b00;
    logic [1:0]    bank_busy = 2'b00;
    logic [7:0]    stat_in = 8'h00;
    logic [DW-1:0] mfr_code = 16'h001C;
    logic [DW-1:0] dev_code = 16'h00A2;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] dout;
    logic          dout_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    // behavioural array contents
    assign mem_rdata = mem_addr[15:0] ^ 16'hA5C3;

    dbank_read_router uut (
        .clk(clk), .pd_n(pd_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
        .mode_ld(mode_ld), .mode_sel(mode_sel), .bank_busy(bank_busy),
        .stat_in(stat_in), .mfr_code(mfr_code), .dev_code(dev_code),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .dout(dout), .dout_oe(dout_oe)
    );

    // {addr, mode, busy, stat, expected}
    localparam logic [47:0] VEC [NV] = '{
        {20'h00010, 2'b00, 2'b00, 8'h11, 16'hA5D3},  // R2 plain array
        {20'h30004, 2'b00, 2'b01, 8'h12, 16'hA5C7},  // R2 other bank busy
        {20'h00005, 2'b00, 2'b01, 8'h22, 16'h0022},  // R1 busy lower bank
        {20'h30000, 2'b00, 2'b10, 8'h33, 16'h0033},  // R1 busy upper bank
        {20'h00000, 2'b10, 2'b00, 8'h34, 16'h001C},  // R3 manufacturer
        {20'h00001, 2'b10, 2'b00, 8'h35, 16'h00A2},  // R3 device
        {20'h00002, 2'b10, 2'b00, 8'h36, 16'h0000},  // R3 other address
        {20'h0FFFF, 2'b01, 2'b00, 8'h44, 16'h0044},  // R10 status mode
        {20'h1FFFF, 2'b11, 2'b01, 8'h55, 16'h0055},  // R9 last lower address
        {20'h20000, 2'b11, 2'b01, 8'h56, 16'hA5C3}   // R9 first upper address
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_mode(input logic [1:0] m);
        mode_sel = m; mode_ld = 1'b1;
        cyc(1);
        mode_ld = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // reset state, R5 and R6
        cyc(2);
        check("R5 oe off in power-down", {15'd0, dout_oe}, 16'd0);
        check("R6 data cleared in power-down", dout, 16'h0000);
        addr = 20'h00010;
        pd_n = 1'b1;
        cyc(2);
        check("R6 default mode is array", dout, 16'hA5D3);
        load_mode(2'b01);
        cyc(1);
        check("R6 status reads 80h", dout, 16'h0080);

        // vector table
        ce_n = 1'b0;
        for (int i = 0; i < NV; i++) begin
            addr = VEC[i][47:28]; bank_busy = VEC[i][25:24]; stat_in = VEC[i][23:16];
            mode_sel = VEC[i][27:26]; mode_ld = 1'b1; oe_n = 1'b1;
            cyc(1);
            mode_ld = 1'b0; oe_n = 1'b0;
            cyc(2);
            check($sformatf("R1/R2/R3/R9/R10 vector %0d", i), dout, VEC[i][15:0]);
        end

        // R5 strobe gating
        check("R5 enabled with both strobes low", {15'd0, dout_oe}, 16'd1);
        oe_n = 1'b1; #1;
        check("R5 oe_n high", {15'd0, dout_oe}, 16'd0);
        oe_n = 1'b0; ce_n = 1'b1; #1;
        check("R5 ce_n high", {15'd0, dout_oe}, 16'd0);

        // R4 capture rules
        bank_busy = 2'b00; addr = 20'h00040; load_mode(2'b01);
        ce_n = 1'b0; oe_n = 1'b1; stat_in = 8'h61;
        cyc(1); oe_n = 1'b0; cyc(2);
        check("R4 fresh capture", dout, 16'h0061);
        stat_in = 8'h62; cyc(3);
        check("R4 no refresh without toggle", dout, 16'h0061);
        oe_n = 1'b1; ce_n = 1'b1; cyc(1);
        ce_n = 1'b0; stat_in = 8'h64; cyc(1);
        stat_in = 8'h65; oe_n = 1'b0; cyc(2);
        check("R4 later strobe edge value", dout, 16'h0065);

        // R7 / R8 power-save hold
        load_mode(2'b00); addr = 20'h00100; cyc(6);
        bank_busy = 2'b01; cyc(2);
        check("R8 change seen before idle expiry", dout, 16'h0065);
        bank_busy = 2'b00; cyc(30);
        check("R7 array before hold", dout, 16'hA4C3);
        bank_busy = 2'b01; load_mode(2'b10); cyc(3);
        check("R7 output held in power-save", dout, 16'hA4C3);
        addr = 20'h00101; cyc(1);
        check("R8 address change gives fresh read", dout, 16'h0065);

        // R6 leaving power-down again
        bank_busy = 2'b00; ce_n = 1'b1;
        pd_n = 1'b0; cyc(2);
        check("R5 oe off during power-down", {15'd0, dout_oe}, 16'd0);
        pd_n = 1'b1; cyc(2);
        check("R6 mode back to array", dout, 16'hA4C2);
        load_mode(2'b01); cyc(1);
        check("R6 status back to 80h", dout, 16'h0080);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule